// File: doc/BRIEF.md
# Keyboard controller command processor

This block is the host-facing half of a PC-style keyboard controller. The host sees two byte-wide ports: a data port and a command/status port. Reading the command port returns the status register. Writing it issues a controller command. The block decodes each command against three internal registers: an 8-bit mode register, an 8-bit status register and an 8-bit output port. Depending on the command, it queues a reply byte, changes a register bit, requests a system reset, or arms a two-phase operation.

A two-phase command only remembers which operation is waiting. The next data-port write supplies the argument, is steered to that operation, and then clears the waiting code. A data write with nothing waiting goes to the keyboard transmit path. Reply bytes leave through a one-cycle push strobe tagged keyboard or auxiliary, for a downstream output buffer. The reset request is a one-cycle pulse. The A20 gate level follows bit 1 of the output port. The serial device links and the device-side command handling belong to other blocks.

Top module: `kbc_cmd_core`

## Requirements
- R1: After reset the status byte reads 0x18 and `a20_gate` is 1. A mode read returns 0x03 and an output-port read returns 0xCF. No strobe is raised while reset is held.
- R2: Command 0x20 replies with the mode byte and command 0xD0 with the output port byte. Command 0xC0 replies 0x80, and commands 0xA9 and 0xAB each reply 0x00. Every such reply is a keyboard-tagged push (`reply_aux` = 0) raised in the cycle after the write is sampled.
- R3: Command 0xAA sets status bit 2 (value 0x04) and replies 0x55. Apart from this bit, no command or data write changes the status byte.
- R4: Commands 0xA7 and 0xA8 set and clear mode bit 5 (value 0x20). Commands 0xAD and 0xAE set and clear mode bit 4 (value 0x10). No reply is pushed for any of the four.
- R5: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 produce no output of their own. They arm a waiting code for the next data write, which that code steers as follows:
  - 0x60 loads the mode register.
  - 0xD1 writes the output port.
  - 0xD2 pushes the byte as a keyboard-tagged reply.
  - 0xD3 pushes the byte as an auxiliary-tagged reply (`reply_aux` = 1).
  - 0xD4 sends the byte on the mouse transmit strobe.
  That data write clears the waiting code.
- R6: A data write with no waiting code raises `kbd_tx_push` in the next cycle, carrying the byte on `tx_byte`.
- R7: An output-port write stores the byte and drives `a20_gate` from bit 1 of the byte. If bit 0 of the byte is 0, it also raises `sys_reset_req`.
- R8: Command 0xDF sets output-port bit 1 and `a20_gate`. Command 0xDD clears both. Neither pushes a reply.
- R9: A command whose upper nibble is 0xF raises `sys_reset_req` when its bit 0 is 0 and otherwise has no effect. This includes 0xFE and 0xFF.
- R10: Any other command code pushes nothing and leaves the mode, status and output port unchanged. It also keeps a waiting code armed.
- R11: `sys_reset_req` and `reply_push` are single-cycle strobes. Each is high only in the cycle after the write that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| wr_cmd | input | 1 | 1 = command port, 0 = data port |
| wr_byte | input | 8 | Byte written by the host |
| status_byte | output | 8 | Status register (command-port read value) |
| reply_push | output | 1 | One-cycle push of a reply byte |
| reply_byte | output | 8 | Reply byte |
| reply_aux | output | 1 | Reply source tag: 1 auxiliary, 0 keyboard |
| kbd_tx_push | output | 1 | Byte to forward to the keyboard device |
| aux_tx_push | output | 1 | Byte to forward to the mouse device |
| tx_byte | output | 8 | Forwarded byte |
| sys_reset_req | output | 1 | One-cycle system reset request |
| a20_gate | output | 1 | A20 gate level (output port bit 1) |

## Verification
The bench issues every listed command, and each one reads a register back through a reply. This separates constant replies from register reads and shows each set/clear pair acting on its own bit. Every two-phase code is followed by a data byte whose route (mode, output port, keyboard inject, auxiliary inject, mouse) shows up on a distinct strobe and tag. A further plain data write then shows the waiting code was cleared. The whole 0xF0–0xFF range is swept to separate even from odd pulse codes. Output-port bytes with bit 0 low and high separate the reset side effect from the A20 effect. Unknown codes are sent both idle and between an armed code and its data byte, to show that nothing changes and the armed route survives.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  localparam int unsigned BW = 8;

  localparam logic [BW-1:0] OP_RD_MODE   = 8'h20;
  localparam logic [BW-1:0] OP_WR_MODE   = 8'h60;
  localparam logic [BW-1:0] OP_AUX_OFF   = 8'hA7;
  localparam logic [BW-1:0] OP_AUX_ON    = 8'hA8;
  localparam logic [BW-1:0] OP_AUX_TEST  = 8'hA9;
  localparam logic [BW-1:0] OP_SELFTEST  = 8'hAA;
  localparam logic [BW-1:0] OP_KBD_TEST  = 8'hAB;
  localparam logic [BW-1:0] OP_KBD_OFF   = 8'hAD;
  localparam logic [BW-1:0] OP_KBD_ON    = 8'hAE;
  localparam logic [BW-1:0] OP_RD_INPUT  = 8'hC0;
  localparam logic [BW-1:0] OP_RD_OUTP   = 8'hD0;
  localparam logic [BW-1:0] OP_WR_OUTP   = 8'hD1;
  localparam logic [BW-1:0] OP_INJ_KBD   = 8'hD2;
  localparam logic [BW-1:0] OP_INJ_AUX   = 8'hD3;
  localparam logic [BW-1:0] OP_TO_MOUSE  = 8'hD4;
  localparam logic [BW-1:0] OP_GATE_OFF  = 8'hDD;
  localparam logic [BW-1:0] OP_GATE_ON   = 8'hDF;

  localparam logic [BW-1:0] MODE_AUX_DIS = 8'h20;
  localparam logic [BW-1:0] MODE_KBD_DIS = 8'h10;
  localparam logic [BW-1:0] STAT_PASSED  = 8'h04;
  localparam logic [BW-1:0] OUTP_GATE    = 8'h02;

  typedef enum logic [2:0] {
    WAIT_NONE, WAIT_MODE, WAIT_OUTP, WAIT_KINJ, WAIT_AINJ, WAIT_MOUSE
  } wait_e;

  typedef enum logic [1:0] {
    RSRC_NONE, RSRC_MODE, RSRC_OUTP, RSRC_CONST
  } rsrc_e;

  typedef struct packed {
    rsrc_e          rsrc;
    logic [BW-1:0]  rconst;
    logic           arm;
    wait_e          arm_code;
    logic [BW-1:0]  mode_set;
    logic [BW-1:0]  mode_clr;
    logic           stat_pass;
    logic           gate_set;
    logic           gate_clr;
    logic           rst_req;
  } cmd_act_t;

  function automatic logic in_pulse_family(logic [BW-1:0] op);
    return op[BW-1:BW-4] == 4'hF;
  endfunction

  function automatic logic pulse_hits_reset(logic [BW-1:0] op);
    return !op[0];
  endfunction

  function automatic logic [BW-1:0] pick_reply(rsrc_e src, logic [BW-1:0] k,
                                               logic [BW-1:0] m, logic [BW-1:0] o);
    case (src)
      RSRC_MODE: return m;
      RSRC_OUTP: return o;
      default:   return k;
    endcase
  endfunction

endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [BW-1:0] op,
  output cmd_act_t      act
);

  always_comb begin
    act          = '0;
    act.rsrc     = RSRC_NONE;
    act.arm_code = WAIT_NONE;
    if (in_pulse_family(op)) begin
      act.rst_req = pulse_hits_reset(op);
    end else begin
      case (op)
        OP_RD_MODE:  act.rsrc = RSRC_MODE;
        OP_RD_OUTP:  act.rsrc = RSRC_OUTP;
        OP_RD_INPUT: begin act.rsrc = RSRC_CONST; act.rconst = 8'h80; end
        OP_AUX_TEST,
        OP_KBD_TEST: begin act.rsrc = RSRC_CONST; act.rconst = 8'h00; end
        OP_SELFTEST: begin
          act.rsrc      = RSRC_CONST;
          act.rconst    = 8'h55;
          act.stat_pass = 1'b1;
        end
        OP_AUX_OFF:  act.mode_set = MODE_AUX_DIS;
        OP_AUX_ON:   act.mode_clr = MODE_AUX_DIS;
        OP_KBD_OFF:  act.mode_set = MODE_KBD_DIS;
        OP_KBD_ON:   act.mode_clr = MODE_KBD_DIS;
        OP_GATE_ON:  act.gate_set = 1'b1;
        OP_GATE_OFF: act.gate_clr = 1'b1;
        OP_WR_MODE:  begin act.arm = 1'b1; act.arm_code = WAIT_MODE;  end
        OP_WR_OUTP:  begin act.arm = 1'b1; act.arm_code = WAIT_OUTP;  end
        OP_INJ_KBD:  begin act.arm = 1'b1; act.arm_code = WAIT_KINJ;  end
        OP_INJ_AUX:  begin act.arm = 1'b1; act.arm_code = WAIT_AINJ;  end
        OP_TO_MOUSE: begin act.arm = 1'b1; act.arm_code = WAIT_MOUSE; end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/kbc_route.sv
module kbc_route
  import kbc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  data_wr,
  input  logic  cmd_wr,
  input  logic  arm,
  input  wait_e arm_code,
  output logic  mode_load,
  output logic  outp_load,
  output logic  kinj,
  output logic  ainj,
  output logic  mouse_fwd,
  output logic  kbd_fwd
);

  wait_e waiting_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                waiting_q <= WAIT_NONE;
    else if (data_wr)          waiting_q <= WAIT_NONE;
    else if (cmd_wr && arm)    waiting_q <= arm_code;
  end

  always_comb begin
    mode_load = 1'b0;
    outp_load = 1'b0;
    kinj      = 1'b0;
    ainj      = 1'b0;
    mouse_fwd = 1'b0;
    kbd_fwd   = 1'b0;
    if (data_wr) begin
      case (waiting_q)
        WAIT_MODE:  mode_load = 1'b1;
        WAIT_OUTP:  outp_load = 1'b1;
        WAIT_KINJ:  kinj      = 1'b1;
        WAIT_AINJ:  ainj      = 1'b1;
        WAIT_MOUSE: mouse_fwd = 1'b1;
        default:    kbd_fwd   = 1'b1;
      endcase
    end
  end

  // R5: a data write always consumes the armed code
  a_r5_wait_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $past(data_wr) |-> waiting_q == WAIT_NONE);

  // R5: at most one data route per write
  a_r5_one_route: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mode_load, outp_load, kinj, ainj, mouse_fwd, kbd_fwd}));

endmodule

// File: rtl/kbc_regs.sv
module kbc_regs
  import kbc_pkg::*;
#(
  parameter logic [BW-1:0] MODE_RST = 8'h03,
  parameter logic [BW-1:0] STAT_RST = 8'h18,
  parameter logic [BW-1:0] OUTP_RST = 8'hCF
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  cmd_act_t      act,
  input  logic          mode_load,
  input  logic          outp_load,
  input  logic [BW-1:0] wbyte,
  output logic [BW-1:0] mode_q,
  output logic [BW-1:0] status_q,
  output logic [BW-1:0] outp_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_RST;
      status_q <= STAT_RST;
      outp_q   <= OUTP_RST;
    end else begin
      if (mode_load)      mode_q <= wbyte;
      else if (cmd_wr)    mode_q <= (mode_q & ~act.mode_clr) | act.mode_set;
      if (cmd_wr && act.stat_pass) status_q <= status_q | STAT_PASSED;
      if (outp_load)      outp_q <= wbyte;
      else if (cmd_wr && act.gate_set) outp_q <= outp_q | OUTP_GATE;
      else if (cmd_wr && act.gate_clr) outp_q <= outp_q & ~OUTP_GATE;
    end
  end

  // R3: status only ever gains the self-test bit
  a_r3_status_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_q) |-> status_q == ($past(status_q) | STAT_PASSED));

  // R7: an output-port load lands the byte
  a_r7_outp_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    $past(outp_load) |-> outp_q == $past(wbyte));

  // R5: a mode load lands the byte
  a_r5_mode_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_load) |-> mode_q == $past(wbyte));

endmodule

// File: rtl/kbc_cmd_core.sv
module kbc_cmd_core
  import kbc_pkg::*;
#(
  parameter logic [BW-1:0] MODE_RST = 8'h03,
  parameter logic [BW-1:0] STAT_RST = 8'h18,
  parameter logic [BW-1:0] OUTP_RST = 8'hCF
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_cmd,
  input  logic [BW-1:0] wr_byte,
  output logic [BW-1:0] status_byte,
  output logic          reply_push,
  output logic [BW-1:0] reply_byte,
  output logic          reply_aux,
  output logic          kbd_tx_push,
  output logic          aux_tx_push,
  output logic [BW-1:0] tx_byte,
  output logic          sys_reset_req,
  output logic          a20_gate
);

  logic          cmd_wr, data_wr;
  cmd_act_t      act;
  logic          mode_load, outp_load, kinj, ainj, mouse_fwd, kbd_fwd;
  logic [BW-1:0] mode_q, status_q, outp_q;
  logic          cmd_reply, cmd_reset, outp_reset;

  assign cmd_wr  = wr_en &&  wr_cmd;
  assign data_wr = wr_en && !wr_cmd;

  kbc_cmd_decode u_dec (.op(wr_byte), .act(act));

  kbc_route u_route (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .cmd_wr(cmd_wr),
    .arm(act.arm), .arm_code(act.arm_code),
    .mode_load(mode_load), .outp_load(outp_load), .kinj(kinj), .ainj(ainj),
    .mouse_fwd(mouse_fwd), .kbd_fwd(kbd_fwd)
  );

  kbc_regs #(.MODE_RST(MODE_RST), .STAT_RST(STAT_RST), .OUTP_RST(OUTP_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .act(act),
    .mode_load(mode_load), .outp_load(outp_load), .wbyte(wr_byte),
    .mode_q(mode_q), .status_q(status_q), .outp_q(outp_q)
  );

  assign cmd_reply  = cmd_wr && (act.rsrc != RSRC_NONE);
  assign cmd_reset  = cmd_wr && act.rst_req;
  assign outp_reset = outp_load && !wr_byte[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reply_push    <= 1'b0;
      reply_byte    <= '0;
      reply_aux     <= 1'b0;
      kbd_tx_push   <= 1'b0;
      aux_tx_push   <= 1'b0;
      tx_byte       <= '0;
      sys_reset_req <= 1'b0;
    end else begin
      reply_push    <= cmd_reply || kinj || ainj;
      reply_aux     <= ainj;
      if (cmd_reply)
        reply_byte <= pick_reply(act.rsrc, act.rconst, mode_q, outp_q);
      else if (kinj || ainj)
        reply_byte <= wr_byte;
      kbd_tx_push   <= kbd_fwd;
      aux_tx_push   <= mouse_fwd;
      if (kbd_fwd || mouse_fwd) tx_byte <= wr_byte;
      sys_reset_req <= cmd_reset || outp_reset;
    end
  end

  assign status_byte = status_q;
  assign a20_gate    = outp_q[1];

  // R11: a reply strobe only follows a sampled write
  a_r11_push_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    reply_push |-> $past(wr_en));

  // R11: a reset pulse only follows a sampled write
  a_r11_reset_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(wr_en));

  // R9: odd pulse-family commands never reset
  a_r9_odd_pulse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_wr && in_pulse_family(wr_byte) && wr_byte[0]) |-> !sys_reset_req);

  // R6: one outgoing strobe per cycle
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reply_push, kbd_tx_push, aux_tx_push}));

endmodule

// File: tb/sim_kbc_cmd_core.sv
module sim_kbc_cmd_core;

  localparam int EV_RK = 0, EV_RA = 1, EV_KTX = 2, EV_ATX = 3, EV_RST = 4;

  typedef struct {
    int          kind;
    logic [7:0]  val;
    string       req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_cmd = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic [7:0] status_byte, reply_byte, tx_byte;
  logic       reply_push, reply_aux, kbd_tx_push, aux_tx_push, sys_reset_req, a20_gate;

  int checks = 0, fails = 0;
  bit done = 0;
  exp_t sb[$];

  always #5 clk = ~clk;

  kbc_cmd_core u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_byte(wr_byte),
    .status_byte(status_byte), .reply_push(reply_push), .reply_byte(reply_byte),
    .reply_aux(reply_aux), .kbd_tx_push(kbd_tx_push), .aux_tx_push(aux_tx_push),
    .tx_byte(tx_byte), .sys_reset_req(sys_reset_req), .a20_gate(a20_gate)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic expect_ev(int kind, logic [7:0] v, string req);
    exp_t e;
    e.kind = kind; e.val = v; e.req = req;
    sb.push_back(e);
  endtask

  task automatic see(int kind, logic [7:0] v);
    exp_t e;
    checks++;
    if (sb.size() == 0) begin
      fails++;
      $display("FAIL unexpected event: actual kind %0d byte %02h expected none", kind, v);
    end else begin
      e = sb.pop_front();
      if (e.kind != kind || e.val !== v) begin
        fails++;
        $display("FAIL %s: actual kind %0d byte %02h expected kind %0d byte %02h",
                 e.req, kind, v, e.kind, e.val);
      end
    end
  endtask

  // monitor: outputs settle after posedge, sampled at negedge
  always @(negedge clk) begin
    if (rst_n) begin
      if (reply_push)    see(reply_aux ? EV_RA : EV_RK, reply_byte);
      if (kbd_tx_push)   see(EV_KTX, tx_byte);
      if (aux_tx_push)   see(EV_ATX, tx_byte);
      if (sys_reset_req) see(EV_RST, 8'h00);
    end else if (reply_push || kbd_tx_push || aux_tx_push || sys_reset_req) begin
      checks++; fails++;
      $display("FAIL R1: strobe during reset actual 1 expected 0");
    end
  end

  task automatic wr(bit cmd, logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_cmd = cmd; wr_byte = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary;
    if (sb.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", status_byte, 8'h18);
    chk("R1", {7'd0, a20_gate}, 8'h01);
    expect_ev(EV_RK, 8'h03, "R1"); wr(1, 8'h20);
    expect_ev(EV_RK, 8'hCF, "R1"); wr(1, 8'hD0);

    // R2 constant replies
    expect_ev(EV_RK, 8'h80, "R2"); wr(1, 8'hC0);
    expect_ev(EV_RK, 8'h00, "R2"); wr(1, 8'hA9);
    expect_ev(EV_RK, 8'h00, "R2"); wr(1, 8'hAB);

    // R11 reply strobe width: high one cycle after write, low after
    expect_ev(EV_RK, 8'h80, "R11");
    @(negedge clk); wr_en = 1; wr_cmd = 1; wr_byte = 8'hC0;
    @(negedge clk); wr_en = 0;
    chk("R11", {7'd0, reply_push}, 8'h01);
    @(negedge clk);
    chk("R11", {7'd0, reply_push}, 8'h00);

    // R3 self test
    expect_ev(EV_RK, 8'h55, "R3"); wr(1, 8'hAA);
    chk("R3", status_byte, 8'h1C);

    // R4 mode bit pairs
    wr(1, 8'hA7); expect_ev(EV_RK, 8'h23, "R4"); wr(1, 8'h20);
    wr(1, 8'hAD); expect_ev(EV_RK, 8'h33, "R4"); wr(1, 8'h20);
    wr(1, 8'hA8); expect_ev(EV_RK, 8'h13, "R4"); wr(1, 8'h20);
    wr(1, 8'hAE); expect_ev(EV_RK, 8'h03, "R4"); wr(1, 8'h20);

    // R6 plain data goes to keyboard
    expect_ev(EV_KTX, 8'h5A, "R6"); wr(0, 8'h5A);

    // R5 two-phase routes
    wr(1, 8'h60); wr(0, 8'h41);
    expect_ev(EV_RK, 8'h41, "R5"); wr(1, 8'h20);
    wr(1, 8'h60); wr(0, 8'h03);
    wr(1, 8'hD2); expect_ev(EV_RK, 8'h77, "R5"); wr(0, 8'h77);
    wr(1, 8'hD3); expect_ev(EV_RA, 8'h88, "R5"); wr(0, 8'h88);
    wr(1, 8'hD4); expect_ev(EV_ATX, 8'h99, "R5"); wr(0, 8'h99);
    expect_ev(EV_KTX, 8'h12, "R5"); wr(0, 8'h12);
    chk("R5", status_byte, 8'h1C);

    // R7 output port writes
    wr(1, 8'hD1); wr(0, 8'hCD);
    chk("R7", {7'd0, a20_gate}, 8'h00);
    expect_ev(EV_RK, 8'hCD, "R7"); wr(1, 8'hD0);
    wr(1, 8'hD1); expect_ev(EV_RST, 8'h00, "R7"); wr(0, 8'hCE);
    chk("R7", {7'd0, a20_gate}, 8'h01);
    expect_ev(EV_RK, 8'hCE, "R7"); wr(1, 8'hD0);
    wr(1, 8'hD1); wr(0, 8'hCF);

    // R8 gate commands
    wr(1, 8'hDD);
    chk("R8", {7'd0, a20_gate}, 8'h00);
    expect_ev(EV_RK, 8'hCD, "R8"); wr(1, 8'hD0);
    wr(1, 8'hDF);
    chk("R8", {7'd0, a20_gate}, 8'h01);
    expect_ev(EV_RK, 8'hCF, "R8"); wr(1, 8'hD0);

    // R9 pulse family sweep
    for (int i = 8'hF0; i <= 8'hFF; i++) begin
      if ((i & 1) == 0) expect_ev(EV_RST, 8'h00, "R9");
      wr(1, 8'(i));
    end

    // R11 reset pulse width
    expect_ev(EV_RST, 8'h00, "R11");
    @(negedge clk); wr_en = 1; wr_cmd = 1; wr_byte = 8'hFE;
    @(negedge clk); wr_en = 0;
    chk("R11", {7'd0, sys_reset_req}, 8'h01);
    @(negedge clk);
    chk("R11", {7'd0, sys_reset_req}, 8'h00);

    // R10 unknown codes
    wr(1, 8'h42); wr(1, 8'h00); wr(1, 8'hB5); wr(1, 8'hE3);
    chk("R10", status_byte, 8'h1C);
    chk("R10", {7'd0, a20_gate}, 8'h01);
    expect_ev(EV_RK, 8'h03, "R10"); wr(1, 8'h20);
    expect_ev(EV_RK, 8'hCF, "R10"); wr(1, 8'hD0);
    wr(1, 8'hD2); wr(1, 8'h42);
    expect_ev(EV_RK, 8'h66, "R10"); wr(0, 8'h66);

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule